// File: doc/BRIEF.md
# Interrupt Wakeup and Force-Request Unit

This unit sits inside an interrupt controller and decides whether a pending interrupt should wake a sleeping system. A wakeup control register holds an enable bit and a three-bit mask level. While the enable bit is set, the unit raises a combinational wakeup line toward the clock-generation logic whenever any active request carries a priority level strictly above the mask. The line has no register stage, so it follows the request inputs in the same cycle.

The unit also keeps a force-request register. Each bit of this register acts as an extra request from its source, at that source's fixed level. Software sets one force bit by writing the bit's index to a write-only set-force address, so no read-modify-write is needed. The force register can also be read and written directly at its own address, which is how software clears forced bits.

Each request index carries a fixed level from 1 to 7, taken from a parameter table. With the default table, indices 0 to 6 have levels 1 to 7, and index 7 has level 1. The bus is one byte wide. Every access completes in the cycle it is presented and gets a ready response, plus an error flag when the access is illegal.

Top module: `irq_wake_unit`

## Requirements
- R1: After reset, the control register reads 0x80 (enable bit 7 = 1, mask bits 2:0 = 0). The force register reads 0x00.
- R2: The control register is at address 0. A write stores bit 7 as the enable and bits 2:0 as the mask. A read returns the stored value with bits 6:3 as zero.
- R3: A mask write of 7 is stored as 6. The stored mask is never 7.
- R4: In the same cycle, wakeOut is 1 exactly when the enable is 1 and some index i, with irqIn[i] or force bit i set, has a level greater than the mask. With the default table, the level of index i is i+1 for i = 0..6, and index 7 has level 1.
- R5: While the enable is 0, wakeOut is 0 whatever requests are pending.
- R6: A write of value n to the set-force address (address 2) sets force bit n. All other force bits keep their values.
- R7: A read of the set-force address returns busErr = 1 with busReady = 1 and rdata = 0.
- R8: The force register at address 1 is read and written directly. A write replaces all of its bits.
- R9: A set-force write with n >= NUM_REQ changes no force bit and returns busErr = 0.
- R10: A force bit counts as a request at its source's level, even when irqIn is all zero.
- R11: busReady equals busSel in every cycle. busErr is 1 only for a selected read of address 2 or any selected access to address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address: 0 control, 1 force, 2 set-force |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data |
| busReady | output | 1 | Access complete |
| busErr | output | 1 | Error response |
| irqIn | input | NUM_REQ | Request inputs |
| forceOut | output | NUM_REQ | Force-request register contents |
| wakeOut | output | 1 | Combinational wakeup to clock generation |

## Verification
The in-RTL assertions check, on every cycle, that the stored mask never reaches 7 and that a cleared enable holds wakeup low. They also check that a valid set-force write leaves its bit set and that an out-of-range index leaves the force register unchanged. Finally, they check the ready and error handshake against the decoded address and direction. The level comparison itself, the clamp of a written 7, and forced bits acting as requests at their source levels are shown only by the bench. It does this by walking request and mask patterns whose wakeup results are worked out from the level table.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  typedef struct packed {
    logic ctrlWr;
    logic forceWr;
    logic setForce;
  } wakeStb_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_FORCE = 2'd1;
  localparam logic [1:0] ADDR_SETF  = 2'd2;
  localparam logic [1:0] ADDR_NONE  = 2'd3;
endpackage

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int NUM_REQ = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [1:0]         busAddr,
  input  logic [7:0]         ctrlVal,
  input  logic [NUM_REQ-1:0] forceVal,
  output wakeStb_t           stb,
  output logic [7:0]         busRdata,
  output logic               busReady,
  output logic               busErr
);
  logic isRead;

  assign isRead = busSel && !busWr;

  always_comb begin
    stb.ctrlWr   = busSel && busWr && (busAddr == ADDR_CTRL);
    stb.forceWr  = busSel && busWr && (busAddr == ADDR_FORCE);
    stb.setForce = busSel && busWr && (busAddr == ADDR_SETF);
  end

  always_comb begin
    busRdata = 8'h00;
    if (isRead) begin
      case (busAddr)
        ADDR_CTRL:  busRdata = ctrlVal;
        ADDR_FORCE: busRdata = 8'(forceVal);
        default:    busRdata = 8'h00;
      endcase
    end
  end

  assign busReady = busSel;
  assign busErr   = busSel && ((busAddr == ADDR_NONE) || (!busWr && busAddr == ADDR_SETF));

  // R7
  setf_read_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == ADDR_SETF) |-> (busErr && busReady && busRdata == 8'h00));

  // R11
  ready_follows_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReady == busSel);

  // R11
  no_idle_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> !busErr);

  // R9
  setf_write_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setForce |-> !busErr);
endmodule

// File: rtl/irq_wake_dp.sv
module irq_wake_dp
  import irq_wake_pkg::*;
#(
  parameter int                     NUM_REQ   = 8,
  parameter logic [3*NUM_REQ-1:0]   LVL_TABLE = {3'd1, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1}
) (
  input  logic               clk,
  input  logic               rstN,
  input  wakeStb_t           stb,
  input  logic [7:0]         wdata,
  input  logic [NUM_REQ-1:0] irqIn,
  output logic [7:0]         ctrlVal,
  output logic [NUM_REQ-1:0] forceVal,
  output logic               wakeOut
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam logic [2:0] MASK_MAX = 3'd6;

  logic               enReg;
  logic [2:0]         maskReg;
  logic [2:0]         maskNext;
  logic [NUM_REQ-1:0] forceReg;
  logic [NUM_REQ-1:0] hit;
  logic [IDX_W-1:0]   setIdx;
  logic               idxOk;

  assign maskNext = (wdata[2:0] > MASK_MAX) ? MASK_MAX : wdata[2:0];
  assign setIdx   = wdata[IDX_W-1:0];
  assign idxOk    = (32'(wdata) < NUM_REQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b1;
      maskReg <= 3'd0;
    end else if (stb.ctrlWr) begin
      enReg   <= wdata[7];
      maskReg <= maskNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forceReg <= '0;
    end else if (stb.forceWr) begin
      forceReg <= wdata[NUM_REQ-1:0];
    end else if (stb.setForce && idxOk) begin
      forceReg[setIdx] <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    assign hit[i] = (irqIn[i] || forceReg[i]) && (LVL_TABLE[3*i +: 3] > maskReg);
  end

  assign wakeOut  = enReg && (|hit);
  assign ctrlVal  = {enReg, 4'b0000, maskReg};
  assign forceVal = forceReg;

  // R3
  mask_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskReg != 3'd7);

  // R5
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |-> !wakeOut);

  // R6
  set_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setForce && idxOk) |=> forceReg[$past(setIdx)]);

  // R9
  bad_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setForce && !idxOk) |=> $stable(forceReg));
endmodule

// File: rtl/irq_wake_unit.sv
module irq_wake_unit
  import irq_wake_pkg::*;
#(
  parameter int                   NUM_REQ   = 8,
  parameter logic [3*NUM_REQ-1:0] LVL_TABLE = {3'd1, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [1:0]         busAddr,
  input  logic [7:0]         busWdata,
  output logic [7:0]         busRdata,
  output logic               busReady,
  output logic               busErr,
  input  logic [NUM_REQ-1:0] irqIn,
  output logic [NUM_REQ-1:0] forceOut,
  output logic               wakeOut
);
  wakeStb_t           stb;
  logic [7:0]         ctrlVal;
  logic [NUM_REQ-1:0] forceVal;

  irq_wake_ctrl #(.NUM_REQ(NUM_REQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .ctrlVal(ctrlVal), .forceVal(forceVal), .stb(stb),
    .busRdata(busRdata), .busReady(busReady), .busErr(busErr)
  );

  irq_wake_dp #(.NUM_REQ(NUM_REQ), .LVL_TABLE(LVL_TABLE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .irqIn(irqIn),
    .ctrlVal(ctrlVal), .forceVal(forceVal), .wakeOut(wakeOut)
  );

  assign forceOut = forceVal;
endmodule

// File: tb/irq_wake_unit_bench.sv
`timescale 1ns/100ps
module irq_wake_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       busReady;
  logic       busErr;
  logic [7:0] irqIn = 8'h00;
  logic [7:0] forceOut;
  logic       wakeOut;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;
  logic [7:0] rdCap;
  logic       errCap;
  logic       rdyCap;

  always #2.5 clk = ~clk;

  irq_wake_unit u_irq_wake_unit (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .busErr(busErr),
    .irqIn(irqIn), .forceOut(forceOut), .wakeOut(wakeOut)
  );

  // {ctrl write, force write, irqIn, 7'b0, expected wake}
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {8'h80, 8'h00, 8'h00, 8'h00},  // R4 idle
    {8'h80, 8'h00, 8'h01, 8'h01},  // R4 level1 > mask0
    {8'h83, 8'h00, 8'h04, 8'h00},  // R4 level3 not > 3
    {8'h83, 8'h00, 8'h08, 8'h01},  // R4 level4 > 3
    {8'h86, 8'h00, 8'h3F, 8'h00},  // R4 levels up to 6 vs mask6
    {8'h86, 8'h00, 8'h40, 8'h01},  // R4 level7 > 6
    {8'h87, 8'h00, 8'h40, 8'h01},  // R3 mask 7 clamped to 6
    {8'h05, 8'h00, 8'hFF, 8'h00},  // R5 disabled
    {8'h82, 8'h04, 8'h00, 8'h01},  // R10 forced level3 > 2
    {8'h82, 8'h82, 8'h00, 8'h00},  // R10 forced levels 2,1 vs 2
    {8'h80, 8'h80, 8'h00, 8'h01}   // R10 forced level1 > 0
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(logic wr, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = a; busWdata = d;
    #1;
    rdCap = busRdata; errCap = busErr; rdyCap = busReady;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  initial begin
    #100000;
    if (!doneFlag) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    access(1'b0, 2'd0, 8'h00);
    check("R1 ctrl", 32'(rdCap), 32'h80);
    access(1'b0, 2'd1, 8'h00);
    check("R1 force", 32'(rdCap), 32'h00);
    check("R11 ready", 32'(rdyCap), 32'h1);
    check("R11 no err", 32'(errCap), 32'h0);

    for (int v = 0; v < NV; v++) begin
      access(1'b1, 2'd0, VEC[v][31:24]);
      access(1'b1, 2'd1, VEC[v][23:16]);
      @(negedge clk);
      irqIn = VEC[v][15:8];
      #1;
      check($sformatf("R4 vector %0d", v), 32'(wakeOut), 32'(VEC[v][0]));
    end
    irqIn = 8'h00;

    // R2 R3 reserved bits and clamp
    access(1'b1, 2'd0, 8'hFF);
    access(1'b0, 2'd0, 8'h00);
    check("R2 R3 readback", 32'(rdCap), 32'h86);
    access(1'b1, 2'd0, 8'h7B);
    access(1'b0, 2'd0, 8'h00);
    check("R2 readback", 32'(rdCap), 32'h03);

    // R8 direct force write/read
    access(1'b1, 2'd1, 8'hA5);
    access(1'b0, 2'd1, 8'h00);
    check("R8 force rw", 32'(rdCap), 32'hA5);
    access(1'b1, 2'd1, 8'h00);

    // R6 set-force by index
    access(1'b1, 2'd2, 8'd3);
    check("R6 set 3", 32'(forceOut), 32'h08);
    access(1'b1, 2'd2, 8'd5);
    check("R6 set 5", 32'(forceOut), 32'h28);
    check("R9 valid setf no err", 32'(errCap), 32'h0);

    // R9 out of range index
    access(1'b1, 2'd2, 8'd9);
    check("R9 ignored", 32'(forceOut), 32'h28);
    check("R9 no err", 32'(errCap), 32'h0);
    access(1'b1, 2'd2, 8'hFF);
    access(1'b0, 2'd1, 8'h00);
    check("R9 readback", 32'(rdCap), 32'h28);

    // R7 set-force read
    access(1'b0, 2'd2, 8'h00);
    check("R7 err", 32'(errCap), 32'h1);
    check("R7 ready", 32'(rdyCap), 32'h1);
    check("R7 rdata", 32'(rdCap), 32'h0);

    // R11 unmapped address
    access(1'b0, 2'd3, 8'h00);
    check("R11 unmapped err", 32'(errCap), 32'h1);

    doneFlag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule